// File: doc/BRIEF.md
# Four-Slot Debug Breakpoint Matcher

This block watches the stream of bus accesses a processor makes. Each access carries an address, a size (byte, word, doubleword) and a kind (instruction fetch, data write, data read). It compares every accepted access against four programmable breakpoint slots. Each slot holds an address, a length qualifier, an access-type qualifier and two enables, one local and one global. When an enabled slot matches, the block raises a one-cycle debug trap and sets a sticky status bit per matching slot. Software clears these bits by writing the status register.

The breakpoint registers sit behind a simple single-cycle register port. A guard bit turns any later register access into a trap instead of letting it complete. The trap records its cause in status and clears the guard bit, so the handler can reach the registers. Single-step and task-switch causes arrive as one-cycle input pulses. They only set their own status bits.

The access stream uses a valid/ready handshake. An access is taken in a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` drops only in the cycle in which `dbg_trap` is high. An access offered in that cycle is not compared, so the source must hold it and present it again. No other back-pressure exists.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset all breakpoint addresses, control and status read as zero, `dbg_trap` is low and `acc_ready` is high.
- R2: The register port acts only when `reg_en` is high. Selects 0-3 address the four breakpoint addresses, 4 the status register and 5 the control register. A write takes effect at the clock edge. A read returns the current value combinationally in the same cycle. Selects 6 and 7 read zero and ignore writes. `reg_rdata` is zero whenever no read completes.
- R3: Control layout: local enable of slot i at bit i, global enable of slot i at bit 4+i, type qualifier of slot i at bits [9+4i:8+4i], length qualifier of slot i at bits [11+4i:10+4i], guard bit at bit 31. Bits 30:24 read zero. Status layout: slot hit bits at bits 3:0, guard cause at bit 4, single-step cause at bit 5, task-switch cause at bit 6. Bits 31:7 read zero.
- R4: Length qualifier 00 compares all address bits. 01 ignores address bit 0. 11 ignores bits 1:0. 10 never matches.
- R5: Access size 00 is a byte, 01 a naturally aligned word, 11 a naturally aligned doubleword, and 10 never matches. A slot matches when the aligned access region and the aligned breakpoint region overlap.
- R6: Access kind 00 is fetch, 01 data write, 10 data read, 11 matches nothing. Type qualifier 00 accepts fetches only, 01 writes only, 11 reads or writes, and 10 nothing.
- R7: A slot takes part in matching only when its local or its global enable is set.
- R8: When an accepted access matches one or more slots, `dbg_trap` is high in the following cycle. At that same edge the hit bit of every matching slot is set, and it stays set until software writes it.
- R9: `acc_ready` is low exactly in the cycles in which `dbg_trap` is high. An access offered then is not compared.
- R10: While the guard bit is set, a register access with `reg_en` high does not complete: no write happens and `reg_rdata` is zero. `dbg_trap` is high in the next cycle, the guard cause bit is set and the guard bit is cleared.
- R11: A `step_pulse` or `task_pulse` sets its status bit at the next edge without raising `dbg_trap`.
- R12: If a software write to status lands in the same cycle as a hardware cause, the hardware-set bits survive the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access offered on the stream |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Access size code (R5) |
| acc_kind | input | 2 | Access kind code (R6) |
| reg_en | input | 1 | Register port access this cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_sel | input | 3 | Register select (R2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| step_pulse | input | 1 | Single-step cause pulse |
| task_pulse | input | 1 | Task-switch cause pulse |
| dbg_trap | output | 1 | Debug trap pulse |

## Verification
Two pairs of functions can coincide in one cycle. In the first, a software write to the status register lands in the same cycle as a matching access or a cause pulse. In the second, a guarded register access arrives together with a matching access. The bench creates both on purpose: it drives the status write with a hitting access, and it offers a second access in the trap cycle. A behavioural model, built on byte-range overlap rather than masks, predicts the trap, the ready and the read data for every cycle. The model decides that the hit bits survive the write and that a stalled access leaves status unchanged.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;

  // access size codes
  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_WORD  = 2'b01;
  localparam logic [1:0] SZ_RSVD  = 2'b10;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  // access kind codes
  localparam logic [1:0] KD_FETCH = 2'b00;
  localparam logic [1:0] KD_WRITE = 2'b01;
  localparam logic [1:0] KD_READ  = 2'b10;

  // slot type qualifier codes
  localparam logic [1:0] QL_EXEC  = 2'b00;
  localparam logic [1:0] QL_WR    = 2'b01;
  localparam logic [1:0] QL_RDWR  = 2'b11;

  // register selects
  localparam logic [2:0] SEL_STAT = 3'd4;
  localparam logic [2:0] SEL_CTRL = 3'd5;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] rw;
  } slot_cfg_t;

  // low address bits that a size or length code leaves out of the compare
  function automatic logic [1:0] span_mask(input logic [1:0] code);
    case (code)
      SZ_WORD:  span_mask = 2'b01;
      SZ_DWORD: span_mask = 2'b11;
      default:  span_mask = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_watch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] bp_addr,
  input  slot_cfg_t     cfg,
  input  logic          armed,
  output logic          hit
);

  logic          len_ok;
  logic          size_ok;
  logic          kind_ok;
  logic [1:0]    lo_mask;
  logic [AW-1:0] cmp_mask;

  always_comb begin
    len_ok  = (cfg.len != SZ_RSVD);
    size_ok = (acc_size != SZ_RSVD);
    // aligned power-of-two regions overlap iff equal under the wider mask
    lo_mask  = span_mask(cfg.len) | span_mask(acc_size);
    cmp_mask = {{(AW-2){1'b1}}, ~lo_mask};
    case (cfg.rw)
      QL_EXEC: kind_ok = (acc_kind == KD_FETCH);
      QL_WR:   kind_ok = (acc_kind == KD_WRITE);
      QL_RDWR: kind_ok = (acc_kind == KD_WRITE) || (acc_kind == KD_READ);
      default: kind_ok = 1'b0;
    endcase
    hit = armed && len_ok && size_ok && kind_ok &&
          ((acc_addr & cmp_mask) == (bp_addr & cmp_mask));
  end

endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_watch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NUM_BP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_BP-1:0]    hit_vec,
  input  logic                 step_pulse,
  input  logic                 task_pulse,
  output logic [NUM_BP*AW-1:0] bp_flat,
  output logic [NUM_BP*4-1:0]  cfg_flat,
  output logic [NUM_BP-1:0]    slot_armed,
  output logic                 guard_trap,
  output logic                 gd_now,
  output logic [NUM_BP+2:0]    stat_now
);

  localparam int DW      = 32;
  localparam int IDXW    = $clog2(NUM_BP);
  localparam int GLB_LSB = NUM_BP;
  localparam int CFG_LSB = 2 * NUM_BP;
  localparam int CFG_END = CFG_LSB + 4 * NUM_BP;
  localparam int GD_BIT  = DW - 1;
  localparam int BD_BIT  = NUM_BP;
  localparam int BS_BIT  = NUM_BP + 1;
  localparam int BT_BIT  = NUM_BP + 2;
  localparam logic [2:0] SEL_BP_END = 3'(NUM_BP);

  logic [AW-1:0]     bp_q  [NUM_BP];
  slot_cfg_t         cfg_q [NUM_BP];
  logic [NUM_BP-1:0] loc_q, glb_q, b_q;
  logic              gd_q, bd_q, bs_q, bt_q;
  logic              wr_ok, rd_ok, wr_stat, wr_ctrl;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[GD_BIT-1:CFG_END];

  assign guard_trap = reg_en && gd_q;
  assign wr_ok      = reg_en && reg_we && !gd_q;
  assign rd_ok      = reg_en && !reg_we && !gd_q;
  assign wr_stat    = wr_ok && (reg_sel == SEL_STAT);
  assign wr_ctrl    = wr_ok && (reg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BP; i++) begin
        bp_q[i]  <= '0;
        cfg_q[i] <= '0;
      end
      loc_q <= '0;
      glb_q <= '0;
      b_q   <= '0;
      gd_q  <= 1'b0;
      bd_q  <= 1'b0;
      bs_q  <= 1'b0;
      bt_q  <= 1'b0;
    end else begin
      if (wr_ok && (reg_sel < SEL_BP_END))
        bp_q[reg_sel[IDXW-1:0]] <= reg_wdata[AW-1:0];
      if (wr_ctrl) begin
        loc_q <= reg_wdata[0 +: NUM_BP];
        glb_q <= reg_wdata[GLB_LSB +: NUM_BP];
        for (int i = 0; i < NUM_BP; i++)
          cfg_q[i] <= reg_wdata[CFG_LSB + 4*i +: 4];
      end
      if (guard_trap)   gd_q <= 1'b0;
      else if (wr_ctrl) gd_q <= reg_wdata[GD_BIT];
      // hardware causes are ORed after a software write so they win
      b_q  <= (wr_stat ? reg_wdata[NUM_BP-1:0] : b_q) | hit_vec;
      bd_q <= (wr_stat ? reg_wdata[BD_BIT] : bd_q) | guard_trap;
      bs_q <= (wr_stat ? reg_wdata[BS_BIT] : bs_q) | step_pulse;
      bt_q <= (wr_stat ? reg_wdata[BT_BIT] : bt_q) | task_pulse;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_ok) begin
      if (reg_sel < SEL_BP_END) begin
        reg_rdata = DW'(bp_q[reg_sel[IDXW-1:0]]);
      end else if (reg_sel == SEL_STAT) begin
        reg_rdata[NUM_BP-1:0] = b_q;
        reg_rdata[BD_BIT]     = bd_q;
        reg_rdata[BS_BIT]     = bs_q;
        reg_rdata[BT_BIT]     = bt_q;
      end else if (reg_sel == SEL_CTRL) begin
        reg_rdata[0 +: NUM_BP]       = loc_q;
        reg_rdata[GLB_LSB +: NUM_BP] = glb_q;
        for (int i = 0; i < NUM_BP; i++)
          reg_rdata[CFG_LSB + 4*i +: 4] = cfg_q[i];
        reg_rdata[GD_BIT] = gd_q;
      end
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_flat
    assign bp_flat[g*AW +: AW] = bp_q[g];
    assign cfg_flat[g*4 +: 4]  = cfg_q[g];
  end

  assign slot_armed = loc_q | glb_q;
  assign gd_now     = gd_q;
  assign stat_now   = {bt_q, bs_q, bd_q, b_q};

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NUM_BP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          step_pulse,
  input  logic          task_pulse,
  output logic          dbg_trap
);

  localparam int BD_IDX = NUM_BP;
  localparam int BS_IDX = NUM_BP + 1;
  localparam int BT_IDX = NUM_BP + 2;

  logic [NUM_BP*AW-1:0] bp_flat;
  logic [NUM_BP*4-1:0]  cfg_flat;
  logic [NUM_BP-1:0]    slot_armed;
  logic [NUM_BP-1:0]    hit_raw;
  logic [NUM_BP-1:0]    hit_vec;
  logic                 guard_trap;
  logic                 gd_now;
  logic [NUM_BP+2:0]    stat_now;
  logic                 trap_q;
  logic                 take;

  assign acc_ready = !trap_q;
  assign take      = acc_valid && acc_ready;
  assign hit_vec   = hit_raw & {NUM_BP{take}};
  assign dbg_trap  = trap_q;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
    dbg_slot_cmp #(.AW(AW)) u_cmp (
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .acc_kind (acc_kind),
      .bp_addr  (bp_flat[g*AW +: AW]),
      .cfg      (cfg_flat[g*4 +: 4]),
      .armed    (slot_armed[g]),
      .hit      (hit_raw[g])
    );
  end

  dbg_regs #(.AW(AW), .NUM_BP(NUM_BP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .hit_vec    (hit_vec),
    .step_pulse (step_pulse),
    .task_pulse (task_pulse),
    .bp_flat    (bp_flat),
    .cfg_flat   (cfg_flat),
    .slot_armed (slot_armed),
    .guard_trap (guard_trap),
    .gd_now     (gd_now),
    .stat_now   (stat_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= (|hit_vec) || guard_trap;
  end

  // R8
  hit_sets_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> (dbg_trap && ((stat_now[NUM_BP-1:0] & $past(hit_vec)) == $past(hit_vec))));

  // R9
  stall_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready && !(reg_en && reg_we && reg_sel == SEL_STAT))
      |=> $stable(stat_now[NUM_BP-1:0]));

  // R10
  guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_trap |=> (dbg_trap && !gd_now && stat_now[BD_IDX]));

  // R10
  guard_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && gd_now) |-> (reg_rdata == '0));

  // R11
  step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !(|hit_vec) && !guard_trap) |=> (!dbg_trap && stat_now[BS_IDX]));

  // R11
  task_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_pulse && !(|hit_vec) && !guard_trap) |=> (!dbg_trap && stat_now[BT_IDX]));

endmodule

// File: tb/dbg_watch_unit_test.sv
module dbg_watch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_ready;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic [1:0]  acc_kind;
  logic        reg_en;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        step_pulse;
  logic        task_pulse;
  logic        dbg_trap;

  int    checks   = 0;
  int    failures = 0;
  int    cycles   = 0;
  string phase    = "R1";

  logic [31:0] m_bp [4];
  logic [31:0] m_ctrl;
  logic [31:0] m_stat;
  bit          m_trap;

  localparam logic [31:0] CTRL_KEEP = 32'h80FF_FFFF;
  localparam logic [31:0] STAT_KEEP = 32'h0000_007F;

  always #2 clk = ~clk;

  dbg_watch_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
    .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .step_pulse(step_pulse), .task_pulse(task_pulse),
    .dbg_trap(dbg_trap)
  );

  function automatic int span_bytes(logic [1:0] c);
    case (c)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b11:   return 4;
      default: return 0;
    endcase
  endfunction

  // byte-range overlap model of one slot (R4-R7)
  function automatic bit slot_hit(int s, logic [31:0] a, logic [1:0] sz, logic [1:0] k);
    longint unsigned bs, as_;
    int bl, al;
    bit en, kok;
    logic [1:0] rw, ln;
    en = m_ctrl[s] || m_ctrl[4+s];
    rw = m_ctrl[8+4*s +: 2];
    ln = m_ctrl[10+4*s +: 2];
    bl = span_bytes(ln);
    al = span_bytes(sz);
    case (rw)
      2'b00:   kok = (k == 2'b00);
      2'b01:   kok = (k == 2'b01);
      2'b11:   kok = (k == 2'b01) || (k == 2'b10);
      default: kok = 0;
    endcase
    if (!en || !kok || bl == 0 || al == 0) return 0;
    bs  = (longint'(m_bp[s]) / bl) * bl;
    as_ = (longint'(a) / al) * al;
    return (as_ < bs + bl) && (bs < as_ + al);
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  // one clock: drive at the low phase, compare, advance the model at the edge
  task automatic cyc(bit v, logic [31:0] a, logic [1:0] sz, logic [1:0] k,
                     bit en, bit we, logic [2:0] sel, logic [31:0] wd,
                     bit stp = 0, bit tsk = 0);
    logic [31:0] exp_rd;
    logic [3:0]  hits;
    bit          guard;
    acc_valid = v; acc_addr = a; acc_size = sz; acc_kind = k;
    reg_en = en; reg_we = we; reg_sel = sel; reg_wdata = wd;
    step_pulse = stp; task_pulse = tsk;
    #1;
    exp_rd = 32'h0;
    if (en && !we && !m_ctrl[31]) begin
      if (sel < 3'd4)       exp_rd = m_bp[sel];
      else if (sel == 3'd4) exp_rd = m_stat;
      else if (sel == 3'd5) exp_rd = m_ctrl;
    end
    check("trap",  {31'b0, dbg_trap},  {31'b0, m_trap});
    check("ready", {31'b0, acc_ready}, {31'b0, !m_trap});
    check("rdata", reg_rdata, exp_rd);
    @(posedge clk);
    hits = 4'b0;
    if (v && !m_trap)
      for (int s = 0; s < 4; s++) if (slot_hit(s, a, sz, k)) hits[s] = 1'b1;
    guard = en && m_ctrl[31];
    if (en && we && !guard) begin
      if (sel < 3'd4)       m_bp[sel] = wd;
      else if (sel == 3'd4) m_stat = wd & STAT_KEEP;
      else if (sel == 3'd5) m_ctrl = wd & CTRL_KEEP;
    end
    m_stat = m_stat | {25'b0, tsk, stp, guard, hits};
    if (guard) m_ctrl[31] = 1'b0;
    m_trap = (hits != 0) || guard;
    @(negedge clk);
  endtask

  task automatic idle();                        cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [2:0] s, logic [31:0] d); cyc(0, 0, 0, 0, 1, 1, s, d); endtask
  task automatic rd(logic [2:0] s);             cyc(0, 0, 0, 0, 1, 0, s, 0); endtask
  task automatic probe(logic [31:0] a, logic [1:0] sz, logic [1:0] k);
    cyc(1, a, sz, k, 0, 0, 0, 0);
    idle();
    rd(3'd4);
    wr(3'd4, 32'h0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_bp[i] = 32'h0;
    m_ctrl = 0; m_stat = 0; m_trap = 0;
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = 0; acc_size = 0; acc_kind = 0;
    reg_en = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    step_pulse = 0; task_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values on every select
    phase = "R1";
    for (int s = 0; s < 8; s++) rd(3'(s));

    // R2: address registers, empty selects, writes without enable
    phase = "R2";
    wr(3'd0, 32'h1000); wr(3'd1, 32'h1005); wr(3'd2, 32'h100A); wr(3'd3, 32'h1010);
    for (int s = 0; s < 4; s++) rd(3'(s));
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6); rd(3'd7);
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 32'hDEAD_BEEF); rd(3'd0);

    // R3: field masks of control and status
    phase = "R3";
    wr(3'd5, 32'h7FFF_FFFF); rd(3'd5);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4); wr(3'd4, 32'h0); rd(3'd4);

    // R4: slot lengths byte, word, doubleword, reserved
    phase = "R4";
    wr(3'd5, 32'h00BF_730F);
    probe(32'h1000, 2'b00, 2'b10); probe(32'h1001, 2'b00, 2'b10);
    probe(32'h1004, 2'b00, 2'b10); probe(32'h1005, 2'b00, 2'b10);
    probe(32'h1006, 2'b00, 2'b10); probe(32'h1008, 2'b00, 2'b10);
    probe(32'h100B, 2'b00, 2'b10); probe(32'h1010, 2'b00, 2'b10);

    // R5: access sizes
    phase = "R5";
    probe(32'h1000, 2'b01, 2'b10); probe(32'h1004, 2'b11, 2'b01);
    probe(32'h100C, 2'b01, 2'b10); probe(32'h1000, 2'b10, 2'b10);
    probe(32'h1010, 2'b11, 2'b10);

    // R6: type qualifiers against every access kind
    phase = "R6";
    for (int s = 0; s < 4; s++) wr(3'(s), 32'h2000);
    wr(3'd5, 32'h0023_100F);
    for (int k = 0; k < 4; k++) probe(32'h2000, 2'b00, 2'(k));

    // R7: global-only, local-only and disabled slots
    phase = "R7";
    wr(3'd5, 32'h0023_1010);
    probe(32'h2000, 2'b00, 2'b00); probe(32'h2000, 2'b00, 2'b01);
    wr(3'd5, 32'h0023_1002);
    probe(32'h2000, 2'b00, 2'b01); probe(32'h2000, 2'b00, 2'b00);
    wr(3'd5, 32'h0023_1000);
    probe(32'h2000, 2'b00, 2'b00);

    // R8: several slots at once, bits stay until written
    phase = "R8";
    wr(3'd5, 32'h00FF_FF0F);
    cyc(1, 32'h2002, 2'b00, 2'b10, 0, 0, 0, 0);
    idle(); idle(); rd(3'd4); idle(); rd(3'd4); wr(3'd4, 32'h0); rd(3'd4);

    // R9: second access in the trap cycle is stalled
    phase = "R9";
    wr(3'd0, 32'h3000); wr(3'd5, 32'h00FF_FF0F);
    cyc(1, 32'h2000, 2'b00, 2'b10, 0, 0, 0, 0);
    cyc(1, 32'h3000, 2'b00, 2'b10, 0, 0, 0, 0);
    idle(); rd(3'd4); wr(3'd4, 32'h0);
    cyc(1, 32'h3000, 2'b00, 2'b10, 0, 0, 0, 0);
    idle(); rd(3'd4); wr(3'd4, 32'h0);

    // R10: guarded registers
    phase = "R10";
    wr(3'd5, 32'h80FF_FF0F);
    rd(3'd5); idle(); rd(3'd5); rd(3'd4); wr(3'd4, 32'h0);
    wr(3'd5, 32'h80FF_FF0F);
    wr(3'd0, 32'hDEAD_BEEF); idle(); rd(3'd0); rd(3'd4); wr(3'd4, 32'h0);
    wr(3'd5, 32'h80FF_FF0F);
    cyc(1, 32'h2000, 2'b00, 2'b10, 1, 0, 3'd4, 0);
    idle(); rd(3'd4); rd(3'd5); wr(3'd4, 32'h0);

    // R11: step and task-switch pulses
    phase = "R11";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); idle(); rd(3'd4);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); idle(); rd(3'd4);

    // R12: status write meets hardware causes in one cycle
    phase = "R12";
    cyc(1, 32'h2000, 2'b00, 2'b10, 1, 1, 3'd4, 32'h0, 0, 1);
    rd(3'd4); wr(3'd4, 32'h0);
    cyc(0, 0, 0, 0, 1, 1, 3'd4, 32'h0, 1, 0);
    rd(3'd4); wr(3'd4, 32'h0); rd(3'd4);

    // R8: mixed traffic judged by the model on every clock
    phase = "R8";
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  sel;
      logic [31:0] wd;
      sel = 3'($urandom_range(0, 7));
      wd  = (sel < 3'd4) ? (32'h2000 | 32'($urandom_range(0, 15))) : $urandom();
      if (sel == 3'd5 && $urandom_range(0, 3) != 0) wd[31] = 1'b0;
      cyc($urandom_range(0, 1) == 1, 32'h2000 | 32'($urandom_range(0, 15)),
          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
          $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, sel, wd,
          $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule